// File: doc/BRIEF.md
# Segmented Thermometer Code Encoder

This block turns a stream of 12-bit offset-binary samples into the switch controls of a segmented current-steering converter. The six most significant bits choose how many of 63 identical unit elements are switched on. The six least significant bits stay in binary form and drive the binary-weighted part of the array. The analog weighting itself is outside this block.

The unit-element code is built in two register stages. The first stage splits the six upper bits into a 3-bit row field and a 3-bit column field and turns each field into a short thermometer. The second stage combines the two into the 63 element enables. The binary bits pass through matching delay registers. A final register stage then captures every element control and every binary line together, so that they all switch on the same clock edge.

Samples move with a valid/ready handshake. A sample is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` follows `out_ready`. While `out_ready` is low, the whole pipeline holds and no new input is accepted. An empty slot, where `in_valid` is low, travels through the pipeline as a bubble.

Top module: `tcode_encoder`

## Requirements
- R1: For every accepted sample, the number of high `out_therm` lines equals bits [11:6] of the sample, and `out_lsb` equals bits [5:0]. As a result, 64 × (high line count) + `out_lsb` reproduces the sample.
- R2: Whenever `out_valid` is high, `out_therm` is a thermometer. Bit k high implies that every bit below k is high, and the high bits start at bit 0.
- R3: With `out_ready` held high, a sample accepted on clock edge E appears with `out_valid` high in the cycle after edge E+2. That is a fixed latency of 3 clocks.
- R4: Sample 000h gives all 63 `out_therm` lines low and `out_lsb` = 0. Sample FFFh gives all 63 lines high and `out_lsb` = 3Fh.
- R5: A cycle with `in_valid` low that passes through the pipeline makes `out_valid` low 3 clocks later.
- R6: Synchronous active-high `rst` clears every pipeline valid bit. `out_valid` is low in the cycle after any clock edge at which `rst` was high.
- R7: `in_ready` equals `out_ready`. While `out_ready` is low, `out_valid`, `out_therm` and `out_lsb` hold their values, and a sample offered during that time is not accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is valid |
| in_ready | output | 1 | Block can accept a sample |
| in_sample | input | 12 | Offset-binary sample |
| out_valid | output | 1 | Output controls are valid |
| out_ready | input | 1 | Downstream can take the output |
| out_therm | output | 63 | Unit-element enables, bit 0 first on |
| out_lsb | output | 6 | Binary lower bits, latency-matched |

## Verification
The bench sends every one of the 4096 codes through the block back to back. A wrong row/column merge would show up as a gap or an extra element near the row boundaries (codes such as 03Fh/040h and 7FFh/800h). A binary path one register short or long would pair each thermometer with the lower bits of a neighbouring sample. The full-scale codes catch a decoder that fails to reach all 63 elements, or one that wraps the top row. A stall test holds `out_ready` low while a different sample is offered. A leaky enable would change the held output or let the offered sample through. A mid-stream reset and a run of bubbles would expose a valid bit that is not cleared or not pipelined.

// File: rtl/tcode_pkg.sv
package tcode_pkg;
  localparam int MSB_W_DEF = 6;
  localparam int LSB_W_DEF = 6;
  localparam int ROW_W_DEF = 3;

  function automatic int unit_count(input int msb_w);
    return (1 << msb_w) - 1;
  endfunction
endpackage

// File: rtl/tcode_split_stage.sv
module tcode_split_stage
  import tcode_pkg::*;
#(
  parameter int MSB_W = MSB_W_DEF,
  parameter int LSB_W = LSB_W_DEF,
  parameter int ROW_W = ROW_W_DEF
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic                       in_valid,
  input  logic [MSB_W+LSB_W-1:0]     in_sample,
  output logic                       s1_valid,
  output logic [(1<<ROW_W)-1:0]      s1_row_lt,
  output logic [(1<<(MSB_W-ROW_W))-1:0] s1_col_lt,
  output logic [LSB_W-1:0]           s1_lsb
);
  localparam int COL_W = MSB_W - ROW_W;
  localparam int ROWS  = 1 << ROW_W;
  localparam int COLS  = 1 << COL_W;

  logic [ROW_W-1:0] row_f;
  logic [COL_W-1:0] col_f;
  logic [ROWS-1:0]  row_lt_n;
  logic [COLS-1:0]  col_lt_n;

  assign row_f = in_sample[MSB_W+LSB_W-1 -: ROW_W];
  assign col_f = in_sample[LSB_W +: COL_W];

  // Each field becomes a short thermometer: bit i set when i < field.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_lt_n[r] = (ROW_W'(r) < row_f);
  end
  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_lt_n[c] = (COL_W'(c) < col_f);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_row_lt <= '0;
      s1_col_lt <= '0;
      s1_lsb    <= '0;
    end else if (en) begin
      s1_valid  <= in_valid;
      s1_row_lt <= row_lt_n;
      s1_col_lt <= col_lt_n;
      s1_lsb    <= in_sample[LSB_W-1:0];
    end
  end
endmodule

// File: rtl/tcode_merge_stage.sv
module tcode_merge_stage
  import tcode_pkg::*;
#(
  parameter int MSB_W = MSB_W_DEF,
  parameter int LSB_W = LSB_W_DEF,
  parameter int ROW_W = ROW_W_DEF
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          en,
  input  logic                          s1_valid,
  input  logic [(1<<ROW_W)-1:0]         s1_row_lt,
  input  logic [(1<<(MSB_W-ROW_W))-1:0] s1_col_lt,
  input  logic [LSB_W-1:0]              s1_lsb,
  output logic                          s2_valid,
  output logic [(1<<MSB_W)-2:0]         s2_therm,
  output logic [LSB_W-1:0]              s2_lsb
);
  localparam int COL_W = MSB_W - ROW_W;
  localparam int ROWS  = 1 << ROW_W;
  localparam int COLS  = 1 << COL_W;
  localparam int UNITS = unit_count(MSB_W);

  logic [ROWS-1:0]  row_eq;
  logic [UNITS-1:0] therm_n;

  // Row r is the partially filled row when r is not below the field but r-1 is.
  for (genvar r = 0; r < ROWS; r++) begin : g_eq
    if (r == 0) begin : g_first
      assign row_eq[r] = ~s1_row_lt[r];
    end else begin : g_rest
      assign row_eq[r] = ~s1_row_lt[r] & s1_row_lt[r-1];
    end
  end

  // Element r*COLS+c: whole rows below, plus the columns of the current row.
  for (genvar r = 0; r < ROWS; r++) begin : g_r
    for (genvar c = 0; c < COLS; c++) begin : g_c
      if (r * COLS + c < UNITS) begin : g_unit
        assign therm_n[r*COLS+c] = s1_row_lt[r] | (row_eq[r] & s1_col_lt[c]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_therm <= '0;
      s2_lsb   <= '0;
    end else if (en) begin
      s2_valid <= s1_valid;
      s2_therm <= therm_n;
      s2_lsb   <= s1_lsb;
    end
  end
endmodule

// File: rtl/tcode_align_stage.sv
module tcode_align_stage #(
  parameter int W = 69
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         d_valid,
  input  logic [W-1:0] d_bus,
  output logic         q_valid,
  output logic [W-1:0] q_bus
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_bus   <= '0;
    end else if (en) begin
      q_valid <= d_valid;
      q_bus   <= d_bus;
    end
  end
endmodule

// File: rtl/tcode_encoder.sv
module tcode_encoder
  import tcode_pkg::*;
#(
  parameter int MSB_W = MSB_W_DEF,
  parameter int LSB_W = LSB_W_DEF,
  parameter int ROW_W = ROW_W_DEF
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [MSB_W+LSB_W-1:0]    in_sample,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [(1<<MSB_W)-2:0]     out_therm,
  output logic [LSB_W-1:0]          out_lsb
);
  localparam int COL_W = MSB_W - ROW_W;
  localparam int ROWS  = 1 << ROW_W;
  localparam int COLS  = 1 << COL_W;
  localparam int UNITS = unit_count(MSB_W);
  localparam int BUS_W = UNITS + LSB_W;

  logic             adv;
  logic             s1_valid;
  logic [ROWS-1:0]  s1_row_lt;
  logic [COLS-1:0]  s1_col_lt;
  logic [LSB_W-1:0] s1_lsb;
  logic             s2_valid;
  logic [UNITS-1:0] s2_therm;
  logic [LSB_W-1:0] s2_lsb;
  logic [BUS_W-1:0] out_bus;

  // Whole pipeline advances only when downstream takes data.
  assign adv      = out_ready;
  assign in_ready = out_ready;

  tcode_split_stage #(.MSB_W(MSB_W), .LSB_W(LSB_W), .ROW_W(ROW_W)) u_split (
    .clk(clk), .rst(rst), .en(adv),
    .in_valid(in_valid), .in_sample(in_sample),
    .s1_valid(s1_valid), .s1_row_lt(s1_row_lt),
    .s1_col_lt(s1_col_lt), .s1_lsb(s1_lsb)
  );

  tcode_merge_stage #(.MSB_W(MSB_W), .LSB_W(LSB_W), .ROW_W(ROW_W)) u_merge (
    .clk(clk), .rst(rst), .en(adv),
    .s1_valid(s1_valid), .s1_row_lt(s1_row_lt),
    .s1_col_lt(s1_col_lt), .s1_lsb(s1_lsb),
    .s2_valid(s2_valid), .s2_therm(s2_therm), .s2_lsb(s2_lsb)
  );

  tcode_align_stage #(.W(BUS_W)) u_align (
    .clk(clk), .rst(rst), .en(adv),
    .d_valid(s2_valid), .d_bus({s2_therm, s2_lsb}),
    .q_valid(out_valid), .q_bus(out_bus)
  );

  assign out_therm = out_bus[BUS_W-1:LSB_W];
  assign out_lsb   = out_bus[LSB_W-1:0];
endmodule

// File: rtl/tcode_encoder_chk.sv
module tcode_encoder_chk #(
  parameter int MSB_W = 6,
  parameter int LSB_W = 6
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic [MSB_W+LSB_W-1:0] in_sample,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [(1<<MSB_W)-2:0]  out_therm,
  input logic [LSB_W-1:0]       out_lsb
);
  localparam int SW = MSB_W + LSB_W;

  a_r2_monotonic: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_therm & (out_therm + 1'b1)) == '0));

  a_r1_r3_latency_value: assert property (@(posedge clk) disable iff (rst)
    (in_valid && out_ready) ##1 out_ready ##1 out_ready |=>
      (out_valid
       && ($countones(out_therm) == int'($past(in_sample[SW-1:LSB_W], 3)))
       && (out_lsb == $past(in_sample[LSB_W-1:0], 3))));

  a_r5_bubble: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && out_ready) ##1 out_ready ##1 out_ready |=> !out_valid);

  a_r6_reset_clears: assert property (@(posedge clk)
    rst |=> !out_valid);

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_therm) && $stable(out_lsb)));
endmodule

bind tcode_encoder tcode_encoder_chk #(.MSB_W(MSB_W), .LSB_W(LSB_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_therm(out_therm), .out_lsb(out_lsb)
);

// File: tb/sim_tcode_encoder.sv
module sim_tcode_encoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_sample = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [62:0] out_therm;
  logic [5:0]  out_lsb;

  int checks = 0;
  int errors = 0;

  logic       h_v   [3];
  logic [11:0] h_code[3];
  int         h_cnt [3];
  int         h_lsb [3];

  localparam int NVEC = 12;
  localparam logic [11:0] VEC_CODE [NVEC] = '{12'h000, 12'hFFF, 12'h040, 12'h03F,
    12'h800, 12'h7FF, 12'hFC0, 12'h001, 12'hABC, 12'h555, 12'hAAA, 12'h123};
  localparam int VEC_CNT [NVEC] = '{0, 63, 1, 0, 32, 31, 63, 0, 42, 21, 42, 4};
  localparam int VEC_LSB [NVEC] = '{0, 63, 0, 63, 0, 63, 0, 1, 60, 21, 42, 35};

  always #4 clk = ~clk;

  tcode_encoder u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .out_valid(out_valid), .out_ready(out_ready),
    .out_therm(out_therm), .out_lsb(out_lsb)
  );

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic chk(input logic ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic hist_clear();
    for (int i = 0; i < 3; i++) begin
      h_v[i] = 1'b0; h_code[i] = '0; h_cnt[i] = 0; h_lsb[i] = 0;
    end
  endtask

  // One cycle with out_ready high: check the sample sent 3 cycles ago, then drive.
  task automatic step(input logic v, input logic [11:0] code, input int ecnt, input int elsb);
    @(negedge clk);
    if (h_v[2]) begin
      chk(out_valid === 1'b1, "R3", "out_valid after 3 clocks", longint'(out_valid), 1);
      chk($countones(out_therm) == h_cnt[2], "R1", "thermometer count",
          $countones(out_therm), h_cnt[2]);
      chk(int'(out_lsb) == h_lsb[2], "R1", "binary lsb", longint'(out_lsb), h_lsb[2]);
      chk(64 * $countones(out_therm) + int'(out_lsb) == int'(h_code[2]), "R1",
          "reconstructed code", 64 * $countones(out_therm) + int'(out_lsb), h_code[2]);
      chk((out_therm & (out_therm + 63'd1)) == 63'd0, "R2", "monotonic thermometer",
          out_therm, 0);
      if (h_code[2] == 12'h000)
        chk(out_therm == 63'd0 && out_lsb == 6'd0, "R4", "zero code all off",
            out_therm, 0);
      if (h_code[2] == 12'hFFF)
        chk(out_therm == {63{1'b1}} && out_lsb == 6'h3F, "R4", "full code all on",
            out_therm, {63{1'b1}});
    end else begin
      chk(out_valid === 1'b0, "R5", "bubble keeps out_valid low", longint'(out_valid), 0);
    end
    for (int i = 2; i > 0; i--) begin
      h_v[i] = h_v[i-1]; h_code[i] = h_code[i-1]; h_cnt[i] = h_cnt[i-1]; h_lsb[i] = h_lsb[i-1];
    end
    h_v[0] = v; h_code[0] = code; h_cnt[0] = ecnt; h_lsb[0] = elsb;
    in_valid = v;
    in_sample = code;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    hist_clear();
    repeat (3) @(negedge clk);
    // R6: reset state
    chk(out_valid === 1'b0, "R6", "out_valid in reset", longint'(out_valid), 0);
    rst = 1'b0;

    // Table of vectors walked by one loop, with a bubble in between.
    for (int i = 0; i < NVEC; i++) begin
      step(1'b1, VEC_CODE[i], VEC_CNT[i], VEC_LSB[i]);
      if (i == 5) step(1'b0, 12'h5A5, 0, 0);
    end
    repeat (3) step(1'b0, 12'h000, 0, 0);

    // Full sweep of every code, back to back (R1, R2, R3).
    for (int c = 0; c < 4096; c++)
      step(1'b1, 12'(c), c / 64, c % 64);
    repeat (3) step(1'b0, 12'h000, 0, 0);

    // R7: stall holds output and refuses a new sample.
    step(1'b1, 12'hABC, 42, 60);
    step(1'b0, 12'h000, 0, 0);
    step(1'b0, 12'h000, 0, 0);
    @(negedge clk);
    chk(out_valid === 1'b1 && $countones(out_therm) == 42 && out_lsb == 6'd60, "R7",
        "sample present before stall", $countones(out_therm), 42);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_sample = 12'h123;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(in_ready === 1'b0, "R7", "in_ready follows out_ready", longint'(in_ready), 0);
      chk(out_valid === 1'b1 && $countones(out_therm) == 42 && out_lsb == 6'd60, "R7",
          "output held while stalled", $countones(out_therm), 42);
    end
    in_valid  = 1'b0;
    out_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(out_valid === 1'b0, "R7", "offered sample not taken during stall",
          longint'(out_valid), 0);
    end

    // R6: reset in the middle of a stream.
    hist_clear();
    step(1'b1, 12'h7C1, 31, 1);
    step(1'b1, 12'h3E2, 15, 34);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R6", "out_valid after mid-stream reset", longint'(out_valid), 0);
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid === 1'b0, "R6", "pipeline empty after reset", longint'(out_valid), 0);
    end

    report();
  end
endmodule